// File: doc/BRIEF.md
# Multi-User Receive Frame Filter

This block decides which of up to 64 registered users should get a copy of a received frame. It watches the first 22 bytes of the frame as they stream in, takes the final frame length from a separate strobe, and produces one result per frame. The result holds a mask with one bit per user, a drop flag that is set when no user wants the frame, and a tag that tells how the frame was classified: type-field frame, plain 802.2 frame or SNAP frame.

Each user holds its own settings, loaded through a simple register write port. A user can name a unicast station address and a multicast group address. It also picks one protocol selector, which is a type value, a DSAP byte or a 40-bit protocol identifier, depending on the frame format the user expects. A user can also accept every frame (promiscuous) or every multicast frame, can cap the frame size it accepts, and can ask for a second length field after the type to be checked. Frames that fail length validation or are shorter than the minimum frame size are removed. Copying the payload and checking the CRC are handled elsewhere.

The result is a single-cycle pulse. Surrounding logic starts a frame with a start strobe and then feeds header bytes and the length in any order.

Top module: `rx_user_filter`

## Requirements
- R1: After reset every user is disabled (all fields zero) and `res_valid`, `res_mask`, `res_drop` are 0; a frame sent with no user configured yields an empty mask with drop set.
- R2: `sof` is a strobe on a cycle of its own that opens a frame; header bytes or length offered in that cycle are ignored. Only the first 22 header bytes and the first length strobe after `sof` count. `res_valid` is high for exactly one cycle, starting one cycle after the clock edge that accepts the later of the 22nd header byte and the length.
- R3: `res_fmt` is 0 when bytes 12..13 (byte 12 high) are 0x0600 or more. It is 2 when they are lower and bytes 14, 15, 16 are 0xAA, 0xAA, 0x03. It is 1 in every other case.
- R4: A user's address test passes when the destination (bytes 0..5, byte 0 most significant) equals its unicast address. It also passes when the destination is broadcast (all ones), or when the destination is multicast and equals the user's multicast address.
- R5: The protocol selector value is written with `cfg_sel`=2: value in `cfg_wdata[39:0]`, expected format in `cfg_wdata[41:40]`, where 3 means no format. For format 0 it matches bytes 12..13 against `[15:0]`. For format 1 it matches byte 14 against `[7:0]`. For format 2 it matches bytes 17..21 against `[39:0]`, with byte 17 most significant. A user selects a frame through its address and protocol only when both tests pass and its format equals `res_fmt`.
- R6: A user with the promiscuous flag selects every frame, whatever its address and protocol.
- R7: A user with the all-multicast flag selects every frame whose byte 0 bit 0 is 1, whatever its address and protocol.
- R8: A non-zero maximum size removes the user when the frame length exceeds it; a frame exactly at the limit is kept, and 0 means no limit.
- R9: For format 1 and 2 frames, with L the value of bytes 12..13, the frame stays only if L+18 equals the length, or if L+18 is below 64 and the length is exactly 64. Otherwise every user is removed.
- R10: For format 0 frames a user with the second-length flag keeps the frame only when bytes 14..15 (L2) satisfy the same rule with L2+20. Users without the flag are not affected.
- R11: A frame whose length is below 64 yields an empty mask with drop set, even for promiscuous users.
- R12: `res_drop` is 1 exactly when `res_mask` is zero at a result. Outside a result `res_mask` and `res_drop` are 0.
- R13: Configuration writes use `cfg_sel` codes 0 = unicast address, 1 = multicast address, 2 = protocol, 3 = flags (`[0]` enable, `[1]` promiscuous, `[2]` all-multicast, `[3]` second length), 4 = maximum size (`[13:0]`). Other codes are ignored. A disabled user's bit is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_user | input | 6 | User index for the write |
| cfg_sel | input | 3 | Field selector for the write |
| cfg_wdata | input | 48 | Write data |
| sof | input | 1 | Start-of-frame strobe |
| hdr_valid | input | 1 | Header byte valid |
| hdr_byte | input | 8 | Header byte, in frame order |
| len_valid | input | 1 | Frame length valid |
| len_bytes | input | 14 | Frame length in bytes, FCS included |
| res_valid | output | 1 | Result pulse |
| res_mask | output | 64 | One bit per selected user |
| res_drop | output | 1 | No user selected |
| res_fmt | output | 2 | Frame format tag |

## Verification
Every result is due at a fixed point. The capture stage registers the later of the 22nd byte and the length on edge E, and the result register loads on edge E+1. The bench samples on the falling edge after E, where `res_valid` must still be low, then after E+1, where mask, drop and format are compared with its own model, and then once more to see the outputs return to zero. Three arrival orders of the length are used: before the header, alongside the last byte, and after it. Random idle gaps between bytes move the completion edge without changing that two-edge spacing.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int RXF_HDR_BYTES = 22;
    localparam int RXF_LEN_W     = 14;
    localparam int RXF_ADDR_W    = 48;
    localparam int RXF_PID_W     = 40;
    localparam int RXF_MAC_HDR   = 14;
    localparam int RXF_LEN2_HDR  = 16;
    localparam int RXF_FCS       = 4;
    localparam int RXF_NEED_W    = 18;
    localparam logic [15:0] RXF_TYPE_MIN = 16'h0600;

    typedef enum logic [1:0] {
        FMT_ETH2 = 2'd0,
        FMT_LLC  = 2'd1,
        FMT_SNAP = 2'd2,
        FMT_NONE = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        SEL_UCAST  = 3'd0,
        SEL_MCAST  = 3'd1,
        SEL_PROTO  = 3'd2,
        SEL_FLAGS  = 3'd3,
        SEL_MAXLEN = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic                  en;
        logic                  promisc;
        logic                  allmc;
        logic                  len2;
        fmt_e                  pfmt;
        logic [RXF_PID_W-1:0]  pval;
        logic [RXF_ADDR_W-1:0] ucast;
        logic [RXF_ADDR_W-1:0] mcast;
        logic [RXF_LEN_W-1:0]  maxlen;
    } user_cfg_t;

    typedef struct packed {
        logic [RXF_ADDR_W-1:0] dest;
        logic                  is_mc;
        logic                  is_bc;
        fmt_e                  fmt;
        logic [15:0]           etype;
        logic [7:0]            dsap;
        logic [RXF_PID_W-1:0]  pid;
        logic                  llc_len_ok;
        logic                  eth_len2_ok;
        logic                  runt;
    } hdr_info_t;

endpackage

// File: rtl/rxf_hdr_capture.sv
module rxf_hdr_capture
    import rxf_pkg::*;
#(
    parameter int HDR_BYTES = RXF_HDR_BYTES,
    parameter int LEN_W     = RXF_LEN_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sof,
    input  logic                      hdr_valid,
    input  logic [7:0]                hdr_byte,
    input  logic                      len_valid,
    input  logic [LEN_W-1:0]          len_bytes,
    output logic [HDR_BYTES-1:0][7:0] hdr,
    output logic [LEN_W-1:0]          frame_len,
    output logic                      fire
);

    localparam int CW = $clog2(HDR_BYTES + 1);

    typedef struct packed {
        logic [HDR_BYTES-1:0][7:0] hdr;
        logic [CW-1:0]             cnt;
        logic [LEN_W-1:0]          len;
        logic                      got_len;
        logic                      done;
        logic                      fire;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.fire = 1'b0;
        if (sof) begin
            c_d.cnt     = '0;
            c_d.got_len = 1'b0;
            c_d.done    = 1'b0;
        end else begin
            if (hdr_valid && (c_q.cnt < CW'(HDR_BYTES))) begin
                c_d.hdr[c_q.cnt] = hdr_byte;
                c_d.cnt          = c_q.cnt + 1'b1;
            end
            if (len_valid && !c_q.got_len) begin
                c_d.len     = len_bytes;
                c_d.got_len = 1'b1;
            end
            if (!c_q.done && c_d.got_len && (c_d.cnt == CW'(HDR_BYTES))) begin
                c_d.fire = 1'b1;
                c_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.done <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign hdr       = c_q.hdr;
    assign frame_len = c_q.len;
    assign fire      = c_q.fire;

endmodule

// File: rtl/rxf_hdr_parse.sv
module rxf_hdr_parse
    import rxf_pkg::*;
#(
    parameter int HDR_BYTES = RXF_HDR_BYTES,
    parameter int LEN_W     = RXF_LEN_W,
    parameter int MIN_FRAME = 64
) (
    input  logic [HDR_BYTES-1:0][7:0] hdr,
    input  logic [LEN_W-1:0]          frame_len,
    output hdr_info_t                 info
);

    localparam int ADDR_BYTES = RXF_ADDR_W / 8;
    localparam int PID_BYTES  = RXF_PID_W / 8;
    localparam int PID_OFF    = RXF_MAC_HDR + 3;
    localparam logic [RXF_NEED_W-1:0] LLC_EXTRA = RXF_NEED_W'(RXF_MAC_HDR + RXF_FCS);
    localparam logic [RXF_NEED_W-1:0] E2_EXTRA  = RXF_NEED_W'(RXF_LEN2_HDR + RXF_FCS);
    localparam logic [RXF_NEED_W-1:0] MIN_EXT   = RXF_NEED_W'(MIN_FRAME);

    logic [15:0]           len_field;
    logic [15:0]           len2_field;
    logic [RXF_NEED_W-1:0] len_ext;
    logic [RXF_NEED_W-1:0] need_llc;
    logic [RXF_NEED_W-1:0] need_e2;
    logic                  snap_hdr;

    always_comb begin
        info = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            info.dest[RXF_ADDR_W-1-8*i -: 8] = hdr[i];
        end
        for (int i = 0; i < PID_BYTES; i++) begin
            info.pid[RXF_PID_W-1-8*i -: 8] = hdr[PID_OFF+i];
        end
        info.is_mc = hdr[0][0];
        info.is_bc = &info.dest;

        len_field  = {hdr[RXF_MAC_HDR-2], hdr[RXF_MAC_HDR-1]};
        len2_field = {hdr[RXF_MAC_HDR], hdr[RXF_MAC_HDR+1]};
        snap_hdr   = (hdr[RXF_MAC_HDR] == 8'hAA) && (hdr[RXF_MAC_HDR+1] == 8'hAA)
                     && (hdr[RXF_MAC_HDR+2] == 8'h03);

        if (len_field >= RXF_TYPE_MIN) begin
            info.fmt = FMT_ETH2;
        end else if (snap_hdr) begin
            info.fmt = FMT_SNAP;
        end else begin
            info.fmt = FMT_LLC;
        end

        info.etype = len_field;
        info.dsap  = hdr[RXF_MAC_HDR];

        len_ext  = RXF_NEED_W'(frame_len);
        need_llc = RXF_NEED_W'(len_field) + LLC_EXTRA;
        need_e2  = RXF_NEED_W'(len2_field) + E2_EXTRA;

        info.llc_len_ok  = (need_llc == len_ext) || ((need_llc < MIN_EXT) && (len_ext == MIN_EXT));
        info.eth_len2_ok = (need_e2 == len_ext) || ((need_e2 < MIN_EXT) && (len_ext == MIN_EXT));
        info.runt        = (len_ext < MIN_EXT);
    end

endmodule

// File: rtl/rxf_user_table.sv
module rxf_user_table
    import rxf_pkg::*;
#(
    parameter int NUM_USERS = 64,
    parameter int USER_W    = $clog2(NUM_USERS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [USER_W-1:0]            cfg_user,
    input  logic [2:0]                   cfg_sel,
    input  logic [RXF_ADDR_W-1:0]        cfg_wdata,
    output user_cfg_t [NUM_USERS-1:0]    tbl
);

    user_cfg_t [NUM_USERS-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (cfg_we && (int'(cfg_user) < NUM_USERS)) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_UCAST:  tbl_d[cfg_user].ucast = cfg_wdata;
                SEL_MCAST:  tbl_d[cfg_user].mcast = cfg_wdata;
                SEL_PROTO: begin
                    tbl_d[cfg_user].pval = cfg_wdata[RXF_PID_W-1:0];
                    tbl_d[cfg_user].pfmt = fmt_e'(cfg_wdata[RXF_PID_W+1:RXF_PID_W]);
                end
                SEL_FLAGS: begin
                    tbl_d[cfg_user].en      = cfg_wdata[0];
                    tbl_d[cfg_user].promisc = cfg_wdata[1];
                    tbl_d[cfg_user].allmc   = cfg_wdata[2];
                    tbl_d[cfg_user].len2    = cfg_wdata[3];
                end
                SEL_MAXLEN: tbl_d[cfg_user].maxlen = cfg_wdata[RXF_LEN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign tbl = tbl_q;

endmodule

// File: rtl/rxf_user_match.sv
module rxf_user_match
    import rxf_pkg::*;
#(
    parameter int LEN_W = RXF_LEN_W
) (
    input  user_cfg_t        cfg,
    input  hdr_info_t        info,
    input  logic [LEN_W-1:0] frame_len,
    output logic             sel
);

    logic addr_hit;
    logic proto_hit;
    logic interest;
    logic size_ok;
    logic valid_ok;

    always_comb begin
        addr_hit = (info.dest == cfg.ucast) || info.is_bc
                   || (info.is_mc && (info.dest == cfg.mcast));

        case (cfg.pfmt)
            FMT_ETH2: proto_hit = (info.fmt == FMT_ETH2) && (info.etype == cfg.pval[15:0]);
            FMT_LLC:  proto_hit = (info.fmt == FMT_LLC)  && (info.dsap == cfg.pval[7:0]);
            FMT_SNAP: proto_hit = (info.fmt == FMT_SNAP) && (info.pid == cfg.pval);
            default:  proto_hit = 1'b0;
        endcase

        interest = cfg.promisc || (cfg.allmc && info.is_mc) || (addr_hit && proto_hit);
        size_ok  = (cfg.maxlen == '0) || (frame_len <= cfg.maxlen);
        valid_ok = (info.fmt == FMT_ETH2) ? (!cfg.len2 || info.eth_len2_ok) : info.llc_len_ok;
        sel      = cfg.en && interest && size_ok && valid_ok && !info.runt;
    end

endmodule

// File: rtl/rx_user_filter.sv
module rx_user_filter
    import rxf_pkg::*;
#(
    parameter int NUM_USERS = 64,
    parameter int MIN_FRAME = 64,
    parameter int USER_W    = $clog2(NUM_USERS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [USER_W-1:0]      cfg_user,
    input  logic [2:0]             cfg_sel,
    input  logic [RXF_ADDR_W-1:0]  cfg_wdata,
    input  logic                   sof,
    input  logic                   hdr_valid,
    input  logic [7:0]             hdr_byte,
    input  logic                   len_valid,
    input  logic [RXF_LEN_W-1:0]   len_bytes,
    output logic                   res_valid,
    output logic [NUM_USERS-1:0]   res_mask,
    output logic                   res_drop,
    output logic [1:0]             res_fmt
);

    typedef struct packed {
        logic                 valid;
        logic [NUM_USERS-1:0] mask;
        logic                 drop;
        fmt_e                 fmt;
    } res_t;

    logic [RXF_HDR_BYTES-1:0][7:0] hdr;
    logic [RXF_LEN_W-1:0]          frame_len;
    logic                          fire;
    hdr_info_t                     info;
    user_cfg_t [NUM_USERS-1:0]     tbl;
    logic [NUM_USERS-1:0]          sel_vec;
    res_t                          r_d, r_q;

    rxf_hdr_capture #(
        .HDR_BYTES (RXF_HDR_BYTES),
        .LEN_W     (RXF_LEN_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (sof),
        .hdr_valid (hdr_valid),
        .hdr_byte  (hdr_byte),
        .len_valid (len_valid),
        .len_bytes (len_bytes),
        .hdr       (hdr),
        .frame_len (frame_len),
        .fire      (fire)
    );

    rxf_hdr_parse #(
        .HDR_BYTES (RXF_HDR_BYTES),
        .LEN_W     (RXF_LEN_W),
        .MIN_FRAME (MIN_FRAME)
    ) u_parse (
        .hdr       (hdr),
        .frame_len (frame_len),
        .info      (info)
    );

    rxf_user_table #(
        .NUM_USERS (NUM_USERS),
        .USER_W    (USER_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_user  (cfg_user),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .tbl       (tbl)
    );

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
        rxf_user_match #(
            .LEN_W (RXF_LEN_W)
        ) u_match (
            .cfg       (tbl[u]),
            .info      (info),
            .frame_len (frame_len),
            .sel       (sel_vec[u])
        );
    end

    always_comb begin
        r_d = '0;
        if (fire) begin
            r_d.valid = 1'b1;
            r_d.mask  = sel_vec;
            r_d.drop  = ~|sel_vec;
            r_d.fmt   = info.fmt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign res_valid = r_q.valid;
    assign res_mask  = r_q.mask;
    assign res_drop  = r_q.drop;
    assign res_fmt   = r_q.fmt;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
#(
    parameter int NUM_USERS = 64,
    parameter int MIN_FRAME = 64,
    parameter int USER_W    = $clog2(NUM_USERS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [USER_W-1:0]    cfg_user,
    input logic [2:0]           cfg_sel,
    input logic                 cfg_en_bit,
    input logic                 sof,
    input logic                 len_valid,
    input logic [RXF_LEN_W-1:0] len_bytes,
    input logic                 res_valid,
    input logic [NUM_USERS-1:0] res_mask,
    input logic                 res_drop
);

    logic [NUM_USERS-1:0] en_q;
    logic [RXF_LEN_W-1:0] lat_q;
    logic                 got_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            lat_q <= '0;
            got_q <= 1'b0;
        end else begin
            if (cfg_we && (cfg_sel == 3'd3) && (int'(cfg_user) < NUM_USERS)) begin
                en_q[cfg_user] <= cfg_en_bit;
            end
            if (sof) begin
                got_q <= 1'b0;
            end else if (len_valid && !got_q) begin
                got_q <= 1'b1;
                lat_q <= len_bytes;
            end
        end
    end

    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R2
    AST_RES_NEEDS_LEN: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $past(got_q)); // R2
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> (res_mask == '0) && !res_drop); // R12
    AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> ((res_mask & ~$past(en_q)) == '0)); // R13
    AST_RUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && (lat_q < RXF_LEN_W'(MIN_FRAME))) |-> (res_drop && (res_mask == '0))); // R11

endmodule

bind rx_user_filter rxf_checker #(
    .NUM_USERS (NUM_USERS),
    .MIN_FRAME (MIN_FRAME),
    .USER_W    (USER_W)
) u_rxf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_user   (cfg_user),
    .cfg_sel    (cfg_sel),
    .cfg_en_bit (cfg_wdata[0]),
    .sof        (sof),
    .len_valid  (len_valid),
    .len_bytes  (len_bytes),
    .res_valid  (res_valid),
    .res_mask   (res_mask),
    .res_drop   (res_drop)
);

// File: tb/rx_user_filter_bench.sv
`timescale 1ns/1ps
module rx_user_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_user = '0;
    logic [2:0]  cfg_sel = '0;
    logic [47:0] cfg_wdata = '0;
    logic        sof = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [7:0]  hdr_byte = '0;
    logic        len_valid = 1'b0;
    logic [13:0] len_bytes = '0;
    logic        res_valid;
    logic [63:0] res_mask;
    logic        res_drop;
    logic [1:0]  res_fmt;

    always #2.5 clk = ~clk;

    rx_user_filter u_rx_user_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_user(cfg_user),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .sof(sof), .hdr_valid(hdr_valid),
        .hdr_byte(hdr_byte), .len_valid(len_valid), .len_bytes(len_bytes),
        .res_valid(res_valid), .res_mask(res_mask), .res_drop(res_drop), .res_fmt(res_fmt)
    );

    int n_chk = 0;
    int n_err = 0;

    // bench shadow of user settings
    logic [47:0] m_uc [64];
    logic [47:0] m_mc [64];
    logic [39:0] m_pv [64];
    logic [1:0]  m_pf [64];
    logic [3:0]  m_fl [64];
    logic [13:0] m_mx [64];

    logic [7:0]  hb [22];
    int          flen;
    logic [63:0] last_mask;

    logic [47:0] uc_pool [4] = '{48'h0A0000000001, 48'h0A0000000002, 48'h0A0000000003, 48'h0A0000000004};
    logic [47:0] mc_pool [3] = '{48'h01005E000001, 48'h0300000000FF, 48'h09002B000000};
    logic [15:0] ty_pool [3] = '{16'h0800, 16'h6004, 16'h8035};
    logic [7:0]  ds_pool [3] = '{8'h42, 8'hE0, 8'hFE};
    logic [39:0] pd_pool [3] = '{40'h00000080F3, 40'h080007809B, 40'h0000008137};

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wcfg(input int u, input int s, input logic [47:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_user = 6'(u); cfg_sel = 3'(s); cfg_wdata = d;
        case (s)
            0: m_uc[u] = d;
            1: m_mc[u] = d;
            2: begin m_pv[u] = d[39:0]; m_pf[u] = d[41:40]; end
            3: m_fl[u] = d[3:0];
            4: m_mx[u] = d[13:0];
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_users();
        for (int u = 0; u < 64; u++) begin
            for (int s = 0; s < 5; s++) wcfg(u, s, 48'h0);
        end
    endtask

    task automatic predict(output logic [63:0] m, output logic [1:0] f);
        logic [47:0] dst;
        logic [39:0] pid;
        int t, t2, n1, n2;
        bit mc, bc, ok1, ok2, aok, pok, want, sz, vok;
        dst = {hb[0], hb[1], hb[2], hb[3], hb[4], hb[5]};
        pid = {hb[17], hb[18], hb[19], hb[20], hb[21]};
        mc  = hb[0][0];
        bc  = (dst == 48'hFFFFFFFFFFFF);
        t   = {hb[12], hb[13]};
        t2  = {hb[14], hb[15]};
        if (t >= 'h600) f = 2'd0;
        else if (hb[14] == 8'hAA && hb[15] == 8'hAA && hb[16] == 8'h03) f = 2'd2;
        else f = 2'd1;
        n1  = t + 18;
        n2  = t2 + 20;
        ok1 = (n1 == flen) || (n1 < 64 && flen == 64);
        ok2 = (n2 == flen) || (n2 < 64 && flen == 64);
        m = '0;
        if (flen >= 64) begin
            for (int u = 0; u < 64; u++) begin
                aok = (dst == m_uc[u]) || bc || (mc && dst == m_mc[u]);
                case (m_pf[u])
                    2'd0: pok = (f == 2'd0) && (t == int'(m_pv[u][15:0]));
                    2'd1: pok = (f == 2'd1) && (hb[14] == m_pv[u][7:0]);
                    2'd2: pok = (f == 2'd2) && (pid == m_pv[u]);
                    default: pok = 1'b0;
                endcase
                want = m_fl[u][1] || (m_fl[u][2] && mc) || (aok && pok);
                sz   = (m_mx[u] == 0) || (flen <= int'(m_mx[u]));
                vok  = (f == 2'd0) ? (!m_fl[u][3] || ok2) : ok1;
                m[u] = m_fl[u][0] && want && sz && vok;
            end
        end
    endtask

    // order: 0 length after header, 1 length before header, 2 length with last byte
    task automatic frame(input string tag, input int order, input bit gaps);
        logic [63:0] em;
        logic [1:0]  ef;
        predict(em, ef);
        @(negedge clk);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        if (order == 1) begin
            len_valid = 1'b1; len_bytes = 14'(flen);
            @(negedge clk);
            len_valid = 1'b0;
        end
        for (int i = 0; i < 22; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                hdr_valid = 1'b0;
                @(negedge clk);
            end
            hdr_valid = 1'b1; hdr_byte = hb[i];
            if (order == 2 && i == 21) begin
                len_valid = 1'b1; len_bytes = 14'(flen);
            end
            @(negedge clk);
        end
        hdr_valid = 1'b0; len_valid = 1'b0;
        if (order == 0) begin
            len_valid = 1'b1; len_bytes = 14'(flen);
            @(negedge clk);
            len_valid = 1'b0;
        end
        chk({"R2 not early ", tag}, 64'(res_valid), 64'd0);
        @(negedge clk);
        chk({"R2 valid ", tag}, 64'(res_valid), 64'd1);
        chk(tag, res_mask, em);
        chk({"R3 fmt ", tag}, 64'(res_fmt), 64'(ef));
        chk({"R12 drop ", tag}, 64'(res_drop), 64'(em == 0));
        last_mask = res_mask;
        @(negedge clk);
        chk({"R12 idle ", tag}, {res_valid, res_drop, res_mask[61:0]}, 64'd0);
    endtask

    // kind 0 type-field, 1 plain 802.2, 2 SNAP
    task automatic mk(input logic [47:0] dst, input int kind, input logic [39:0] pv,
                      input int fl, input int lfield);
        for (int i = 0; i < 22; i++) hb[i] = 8'h00;
        for (int i = 0; i < 6; i++) hb[i] = dst[47-8*i -: 8];
        hb[6] = 8'h0A; hb[11] = 8'h55;
        flen = fl;
        if (kind == 0) begin
            {hb[12], hb[13]} = pv[15:0];
            {hb[14], hb[15]} = 16'(lfield);
        end else begin
            {hb[12], hb[13]} = 16'(lfield);
            if (kind == 1) begin
                hb[14] = pv[7:0]; hb[15] = 8'h42; hb[16] = 8'h03;
            end else begin
                hb[14] = 8'hAA; hb[15] = 8'hAA; hb[16] = 8'h03;
                for (int i = 0; i < 5; i++) hb[17+i] = pv[39-8*i -: 8];
            end
        end
    endtask

    task automatic random_users();
        for (int u = 0; u < 64; u++) begin
            int pf;
            logic [39:0] pv;
            pf = $urandom % 4;
            pv = (pf == 0) ? 40'(ty_pool[$urandom % 3]) : (pf == 1) ? 40'(ds_pool[$urandom % 3])
                 : pd_pool[$urandom % 3];
            wcfg(u, 0, uc_pool[$urandom % 4]);
            wcfg(u, 1, mc_pool[$urandom % 3]);
            wcfg(u, 2, {6'd0, 2'(pf), pv});
            wcfg(u, 3, 48'({($urandom % 8 == 0), ($urandom % 8 == 0), ($urandom % 16 == 0), ($urandom % 4 != 0)}));
            wcfg(u, 4, ($urandom % 2) ? 48'd0 : 48'(64 + $urandom % 1500));
        end
    endtask

    task automatic random_frame();
        logic [47:0] dst;
        int sel, kind, fl, lf;
        sel = $urandom % 5;
        case (sel)
            0: dst = uc_pool[$urandom % 4];
            1: dst = mc_pool[$urandom % 3];
            2: dst = 48'hFFFFFFFFFFFF;
            3: dst = {$urandom, 16'h0} & 48'hFEFFFFFFFFFF;
            default: dst = {$urandom, 16'h1} | 48'h010000000000;
        endcase
        fl = ($urandom % 8 == 0) ? (62 + $urandom % 4) : (40 + $urandom % 1560);
        kind = $urandom % 3;
        if (kind == 0) begin
            lf = ($urandom % 2) ? fl - 20 : $urandom % 1500;
            if (lf < 0) lf = 0;
            mk(dst, 0, 40'(ty_pool[$urandom % 3]), fl, lf);
        end else begin
            lf = ($urandom % 2) ? fl - 18 : $urandom % 1500;
            if ($urandom % 8 == 0) lf = $urandom % 40;
            mk(dst, kind, (kind == 1) ? 40'(ds_pool[$urandom % 3]) : pd_pool[$urandom % 3], fl, lf);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int u = 0; u < 64; u++) begin
            m_uc[u] = '0; m_mc[u] = '0; m_pv[u] = '0; m_pf[u] = '0; m_fl[u] = '0; m_mx[u] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {res_valid, res_drop, res_mask[61:0]}, 64'd0);

        // R1: nobody configured
        mk(48'hFFFFFFFFFFFF, 0, 40'h0800, 100, 0);
        frame("R1 empty table", 0, 0);
        chk("R1 empty mask", last_mask, 64'd0);

        // R4 / R5 address and protocol
        wcfg(3, 0, uc_pool[0]); wcfg(3, 1, mc_pool[0]);
        wcfg(3, 2, {6'd0, 2'd0, 40'h0800}); wcfg(3, 3, 48'h1);
        mk(uc_pool[0], 0, 40'h0800, 100, 0);  frame("R4 unicast", 0, 0);
        chk("R4 unicast bit", 64'(last_mask[3]), 64'd1);
        mk(48'hFFFFFFFFFFFF, 0, 40'h0800, 100, 0); frame("R4 broadcast", 1, 0);
        chk("R4 broadcast bit", 64'(last_mask[3]), 64'd1);
        mk(mc_pool[0], 0, 40'h0800, 100, 0); frame("R4 multicast", 2, 0);
        chk("R4 multicast bit", 64'(last_mask[3]), 64'd1);
        mk(uc_pool[1], 0, 40'h0800, 100, 0); frame("R4 other addr", 0, 1);
        chk("R4 other addr bit", 64'(last_mask[3]), 64'd0);
        mk(uc_pool[0], 0, 40'h86DD, 100, 0); frame("R5 wrong type", 0, 0);
        chk("R5 wrong type bit", 64'(last_mask[3]), 64'd0);

        wcfg(5, 0, uc_pool[2]); wcfg(5, 2, {6'd0, 2'd1, 40'hE0}); wcfg(5, 3, 48'h1);
        wcfg(6, 0, uc_pool[2]); wcfg(6, 2, {6'd0, 2'd2, 40'h00000080F3}); wcfg(6, 3, 48'h1);
        mk(uc_pool[2], 1, 40'hE0, 200, 182); frame("R5 dsap", 0, 0);
        chk("R5 dsap bits", last_mask & 64'h60, 64'h20);
        mk(uc_pool[2], 2, 40'h00000080F3, 300, 282); frame("R5 snap pid", 1, 0);
        chk("R5 snap bits", last_mask & 64'h60, 64'h40);
        chk("R3 snap tag", 64'(res_fmt), 64'd0);

        // R9 802 length validation
        mk(uc_pool[2], 1, 40'hE0, 200, 181); frame("R9 bad length", 0, 0);
        chk("R9 bad length bit", 64'(last_mask[5]), 64'd0);
        mk(uc_pool[2], 1, 40'hE0, 64, 10); frame("R9 padded", 2, 0);
        chk("R9 padded bit", 64'(last_mask[5]), 64'd1);

        // R8 size limit
        wcfg(3, 4, 48'd200);
        mk(uc_pool[0], 0, 40'h0800, 200, 0); frame("R8 at limit", 0, 0);
        chk("R8 at limit bit", 64'(last_mask[3]), 64'd1);
        mk(uc_pool[0], 0, 40'h0800, 201, 0); frame("R8 over limit", 0, 0);
        chk("R8 over limit bit", 64'(last_mask[3]), 64'd0);

        // R10 second length
        wcfg(7, 0, uc_pool[0]); wcfg(7, 2, {6'd0, 2'd0, 40'h0800}); wcfg(7, 3, 48'h9);
        mk(uc_pool[0], 0, 40'h0800, 150, 130); frame("R10 good len2", 0, 0);
        chk("R10 good len2 bits", last_mask & 64'h88, 64'h88);
        mk(uc_pool[0], 0, 40'h0800, 150, 131); frame("R10 bad len2", 0, 0);
        chk("R10 bad len2 bits", last_mask & 64'h88, 64'h08);

        // R6 / R7 / R11
        wcfg(9, 2, {6'd0, 2'd3, 40'h0}); wcfg(9, 3, 48'h3);
        wcfg(10, 2, {6'd0, 2'd3, 40'h0}); wcfg(10, 3, 48'h5);
        mk(48'h0C1234567890, 1, 40'h77, 90, 72); frame("R6 promisc", 0, 1);
        chk("R6 R7 bits unicast", last_mask & 64'h600, 64'h200);
        mk(48'h0F1234567890, 0, 40'h9999, 90, 0); frame("R7 allmc", 1, 1);
        chk("R7 allmc bits", last_mask & 64'h600, 64'h600);
        mk(48'h0C1234567890, 0, 40'h9999, 63, 0); frame("R11 runt", 0, 0);
        chk("R11 runt drop", 64'(res_drop), 64'd0);
        chk("R11 runt mask", last_mask, 64'd0);
        mk(48'h0C1234567890, 0, 40'h9999, 64, 0); frame("R11 minimum", 0, 0);
        chk("R11 minimum bit", 64'(last_mask[9]), 64'd1);

        // R13 disable and unused selector
        wcfg(9, 3, 48'h2);
        wcfg(9, 5, 48'hFFFFFFFFFFFF);
        mk(48'h0C1234567890, 0, 40'h9999, 90, 0); frame("R13 disabled", 0, 0);
        chk("R13 disabled bit", 64'(last_mask[9]), 64'd0);

        // random phase
        clear_users();
        random_users();
        for (int k = 0; k < 300; k++) begin
            random_frame();
            frame("R4 R5 R6 R7 R8 R9 R10 random", $urandom % 3, 1'($urandom % 2));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule